// File: doc/BRIEF.md
# Dual-Bank Seven-to-One Video Serializer

This block turns parallel pixel words into serial frames for a flat-panel link. Two banks of lanes are provided. The odd bank serves single-pixel operation, and the even bank joins it in dual-pixel operation. Each bank has five data lanes, A to E, and each lane takes a 7-bit slice of its bank's input word. A lane sends seven bits in every pixel-clock period, so one unit interval is one seventh of that period. A separate clock lane sends a fixed pattern that lets the receiver find the frame boundary.

The input words are captured on the pixel clock. An input selects whether the rising or the falling edge is used. The serial side runs on a supplied clock at seven times the pixel rate. A load strobe in that fast domain moves the captured word into the lanes and restarts the slot counter. Within a frame a lane first sends the two low bits of the word loaded before, then bits 6 down to 2 of the word just loaded. Bank enables and per-lane disable bits force the affected serial outputs to a steady low.

Top module: `ser7_dual_bank_tx`

## Requirements
- R1: In the k-th fast-clock cycle after a load edge (k = 0..6), a lane outputs, in this order, bit 1 and then bit 0 of the word from the previous load, followed by bits 6, 5, 4, 3 and 2 of the word from the current load.
- R2: A load strobe sampled high restarts the frame at slot 0. Without a load the slot counter advances each fast cycle and wraps from slot 6 back to 0, so the same frame is sent again.
- R3: When edge_sel is 1, the word loaded is the input present at the last rising pixel-clock edge. When edge_sel is 0, it is the input present at the last falling edge.
- R4: Lane j of a bank (A = 0 up to E = 4) is fed by bits [7j+6:7j] of that bank's data input.
- R5: The odd bank serializes only while odd_en is 1. Otherwise all its outputs are 0.
- R6: The even bank serializes only while even_en and dual_mode are both 1. Otherwise all its outputs are 0.
- R7: Lane-disable bit j of a bank (1 = off) holds that lane's output at 0 and has no effect on the other lanes.
- R8: The clock lane outputs 1,1,0,0,0,1,1 over slots 0 to 6 while odd_en or even_en is 1. Otherwise it outputs 0.
- R9: Reset clears the stored words. Data lanes therefore output 0 during reset and until the first load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for both clock domains |
| pix_clk | input | 1 | Pixel clock used for input capture |
| edge_sel | input | 1 | Capture edge: 1 = rising, 0 = falling |
| odd_data | input | 35 | Odd bank pixel word, 7 bits per lane, lane A lowest |
| even_data | input | 35 | Even bank pixel word, same layout |
| fast_clk | input | 1 | Serial clock at seven times the pixel rate |
| load_stb | input | 1 | Frame load strobe, sampled on fast_clk |
| odd_en | input | 1 | Odd bank enable |
| even_en | input | 1 | Even bank enable |
| dual_mode | input | 1 | 1 = dual-pixel operation (even bank used) |
| odd_lane_off | input | 5 | Per-lane disable for the odd bank, 1 = off |
| even_lane_off | input | 5 | Per-lane disable for the even bank, 1 = off |
| odd_ser | output | 5 | Odd bank serial lane outputs |
| even_ser | output | 5 | Even bank serial lane outputs |
| clk_ser | output | 1 | Clock lane serial output |

## Verification
The bench builds the block with its default parameters: five lanes per bank and seven-bit frames. This keeps the space of bank and lane masks small enough to cover every combination of capture edge, bank enable, dual mode and four lane-mask patterns. For each frame, different words are presented at the rising and the falling edge, so a wrong edge choice changes the result. Each slot of each frame is compared against values the bench derives arithmetically from the previous and current words. Some frames run without a reload, to exercise the wrap and repeat from slot 6 to slot 0.

// File: rtl/ser7_pkg.sv
package ser7_pkg;

   typedef enum logic {
      EDGE_FALL = 1'b0,
      EDGE_RISE = 1'b1
   } cap_edge_e;

   // Clock lane: high in the first two and the last two slots of a frame.
   function automatic logic clk_slot_bit(input int unsigned slot, input int unsigned nbits);
      return (slot < 2) || (slot + 2 >= nbits);
   endfunction

endpackage

// File: rtl/ser7_capture.sv
module ser7_capture
   import ser7_pkg::*;
#(
   parameter int unsigned W = 35
) (
   input  logic         pix_clk,
   input  logic         rst_n,
   input  logic         edge_sel,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);

   logic [W-1:0] rise_q;
   logic [W-1:0] fall_q;

   always_ff @(posedge pix_clk or negedge rst_n) begin
      if (!rst_n) rise_q <= '0;
      else        rise_q <= din;
   end

   always_ff @(negedge pix_clk or negedge rst_n) begin
      if (!rst_n) fall_q <= '0;
      else        fall_q <= din;
   end

   assign dout = (edge_sel == EDGE_RISE) ? rise_q : fall_q;

endmodule

// File: rtl/ser7_phase.sv
module ser7_phase #(
   parameter int unsigned NBITS = 7,
   parameter int unsigned PW    = 3
) (
   input  logic          fast_clk,
   input  logic          rst_n,
   input  logic          load,
   output logic [PW-1:0] phase
);

   localparam logic [PW-1:0] LAST = PW'(NBITS - 1);

   always_ff @(posedge fast_clk or negedge rst_n) begin
      if (!rst_n)              phase <= '0;
      else if (load)           phase <= '0;
      else if (phase == LAST)  phase <= '0;
      else                     phase <= phase + 1'b1;
   end

   AST_PHASE_RANGE: assert property (@(posedge fast_clk) disable iff (!rst_n)
      phase <= LAST) else $error("phase out of range"); // R2
   AST_PHASE_LOAD: assert property (@(posedge fast_clk) disable iff (!rst_n)
      load |=> phase == '0) else $error("load did not restart frame"); // R2
   AST_PHASE_WRAP: assert property (@(posedge fast_clk) disable iff (!rst_n)
      (!load && phase == LAST) |=> phase == '0) else $error("no wrap"); // R2

endmodule

// File: rtl/ser7_lane.sv
module ser7_lane #(
   parameter int unsigned NBITS = 7,
   parameter int unsigned PW    = 3
) (
   input  logic             fast_clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [NBITS-1:0] word,
   input  logic [PW-1:0]    phase,
   input  logic             active,
   output logic             ser_o
);

   logic [NBITS-1:0] cur_q;
   logic [NBITS-1:0] prev_q;
   logic             pick;

   always_ff @(posedge fast_clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q  <= '0;
         prev_q <= '0;
      end else if (load) begin
         prev_q <= cur_q;
         cur_q  <= word;
      end
   end

   // Slots 0,1 carry bits 1,0 of the previous word; later slots walk down from the MSB.
   always_comb begin
      pick = 1'b0;
      if (phase == PW'(0)) pick = prev_q[1];
      if (phase == PW'(1)) pick = prev_q[0];
      for (int s = 2; s < int'(NBITS); s++) begin
         if (phase == PW'(s)) pick = cur_q[NBITS + 1 - s];
      end
   end

   assign ser_o = active & pick;

   AST_WORD_HOLD: assert property (@(posedge fast_clk) disable iff (!rst_n)
      !load |=> ($stable(cur_q) && $stable(prev_q))) else $error("word changed without load"); // R1

endmodule

// File: rtl/ser7_dual_bank_tx.sv
module ser7_dual_bank_tx
   import ser7_pkg::*;
#(
   parameter int unsigned LANES = 5,
   parameter int unsigned NBITS = 7
) (
   input  logic                   rst_n,
   input  logic                   pix_clk,
   input  logic                   edge_sel,
   input  logic [LANES*NBITS-1:0] odd_data,
   input  logic [LANES*NBITS-1:0] even_data,
   input  logic                   fast_clk,
   input  logic                   load_stb,
   input  logic                   odd_en,
   input  logic                   even_en,
   input  logic                   dual_mode,
   input  logic [LANES-1:0]       odd_lane_off,
   input  logic [LANES-1:0]       even_lane_off,
   output logic [LANES-1:0]       odd_ser,
   output logic [LANES-1:0]       even_ser,
   output logic                   clk_ser
);

   localparam int unsigned W  = LANES * NBITS;
   localparam int unsigned PW = $clog2(NBITS);

   if (NBITS < 3) begin : g_bad_bits
      $error("NBITS must be at least 3");
   end
   if (LANES < 1) begin : g_bad_lanes
      $error("LANES must be at least 1");
   end

   logic [PW-1:0]         phase;
   logic [1:0][W-1:0]     bank_din;
   logic [1:0]            bank_on;
   logic [1:0][LANES-1:0] bank_off;
   logic [1:0][LANES-1:0] bank_ser;

   assign bank_din[0] = odd_data;
   assign bank_din[1] = even_data;
   assign bank_on[0]  = odd_en;
   assign bank_on[1]  = even_en & dual_mode;
   assign bank_off[0] = odd_lane_off;
   assign bank_off[1] = even_lane_off;

   ser7_phase #(.NBITS(NBITS), .PW(PW)) u_phase (
      .fast_clk (fast_clk),
      .rst_n    (rst_n),
      .load     (load_stb),
      .phase    (phase)
   );

   for (genvar b = 0; b < 2; b++) begin : g_bank
      logic [W-1:0] cap_w;

      ser7_capture #(.W(W)) u_cap (
         .pix_clk  (pix_clk),
         .rst_n    (rst_n),
         .edge_sel (edge_sel),
         .din      (bank_din[b]),
         .dout     (cap_w)
      );

      for (genvar j = 0; j < LANES; j++) begin : g_lane
         ser7_lane #(.NBITS(NBITS), .PW(PW)) u_lane (
            .fast_clk (fast_clk),
            .rst_n    (rst_n),
            .load     (load_stb),
            .word     (cap_w[j*NBITS +: NBITS]),
            .phase    (phase),
            .active   (bank_on[b] & ~bank_off[b][j]),
            .ser_o    (bank_ser[b][j])
         );
      end
   end

   assign odd_ser  = bank_ser[0];
   assign even_ser = bank_ser[1];
   assign clk_ser  = (odd_en | even_en) & clk_slot_bit(int'(phase), NBITS);

   AST_ODD_OFF: assert property (@(posedge fast_clk) disable iff (!rst_n)
      !odd_en |-> odd_ser == '0) else $error("odd bank active while off"); // R5
   AST_EVEN_SINGLE: assert property (@(posedge fast_clk) disable iff (!rst_n)
      !(even_en && dual_mode) |-> even_ser == '0) else $error("even bank active"); // R6
   AST_LANE_OFF: assert property (@(posedge fast_clk) disable iff (!rst_n)
      ((odd_lane_off & odd_ser) == '0) && ((even_lane_off & even_ser) == '0))
      else $error("disabled lane toggled"); // R7
   AST_CLK_AFTER_LOAD: assert property (@(posedge fast_clk) disable iff (!rst_n)
      load_stb |=> (clk_ser || !(odd_en || even_en))) else $error("slot0 clock low"); // R8

endmodule

// File: tb/ser7_dual_bank_tx_tb.sv
module ser7_dual_bank_tx_tb_top;

   localparam int unsigned LANES      = 5;
   localparam int unsigned NBITS      = 7;
   localparam int unsigned W          = LANES * NBITS;
   localparam int          CLK_PERIOD = 10;

   logic             rst_n = 1'b0;
   logic             pix_clk = 1'b0;
   logic             fast_clk = 1'b0;
   logic             edge_sel = 1'b1;
   logic [W-1:0]     odd_data = '0;
   logic [W-1:0]     even_data = '0;
   logic             load_stb = 1'b0;
   logic             odd_en = 1'b1;
   logic             even_en = 1'b1;
   logic             dual_mode = 1'b1;
   logic [LANES-1:0] odd_lane_off = '0;
   logic [LANES-1:0] even_lane_off = '0;
   logic [LANES-1:0] odd_ser;
   logic [LANES-1:0] even_ser;
   logic             clk_ser;

   int n_checks = 0;
   int n_fail   = 0;
   logic [W-1:0] cur_o = '0, prev_o = '0, cur_e = '0, prev_e = '0;
   logic [63:0]  rng = 64'h9E37_79B9_7F4A_7C15;

   ser7_dual_bank_tx #(.LANES(LANES), .NBITS(NBITS)) dut_i (
      .rst_n(rst_n), .pix_clk(pix_clk), .edge_sel(edge_sel),
      .odd_data(odd_data), .even_data(even_data), .fast_clk(fast_clk),
      .load_stb(load_stb), .odd_en(odd_en), .even_en(even_en),
      .dual_mode(dual_mode), .odd_lane_off(odd_lane_off),
      .even_lane_off(even_lane_off), .odd_ser(odd_ser),
      .even_ser(even_ser), .clk_ser(clk_ser)
   );

   always #(CLK_PERIOD/2) fast_clk = ~fast_clk;

   // Pixel clock: period 7 fast cycles, edges kept off the fast-clock edges.
   initial begin
      #2;
      forever begin
         pix_clk = 1'b1; #(4*CLK_PERIOD);
         pix_clk = 1'b0; #(3*CLK_PERIOD);
      end
   end

   function automatic logic [W-1:0] next_word();
      rng = rng ^ (rng << 13);
      rng = rng ^ (rng >> 7);
      rng = rng ^ (rng << 17);
      return rng[W-1:0];
   endfunction

   // R1: slot s carries prev bit1, prev bit0, then cur bits 6..2.
   function automatic logic slot_bit(input logic [NBITS-1:0] p, input logic [NBITS-1:0] c, input int s);
      if (s == 0) return p[1];
      if (s == 1) return p[0];
      return c[NBITS + 1 - s];
   endfunction

   function automatic logic [LANES-1:0] bank_exp(input logic [W-1:0] p, input logic [W-1:0] c,
                                                  input logic on, input logic [LANES-1:0] off, input int s);
      logic [LANES-1:0] r;
      for (int j = 0; j < LANES; j++)   // R4: lane j uses bits [7j+6:7j]
         r[j] = on & ~off[j] & slot_bit(p[j*NBITS +: NBITS], c[j*NBITS +: NBITS], s);
      return r;
   endfunction

   task automatic check_vec(input string tag, input logic [LANES-1:0] act, input logic [LANES-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s t=%0t actual=%b expected=%b", tag, $time, act, exp);
      end
   endtask

   task automatic check_slot(input int s, input bit wrapped);
      logic [LANES-1:0] eo, ee;
      logic             ec;
      eo = bank_exp(prev_o, cur_o, odd_en, odd_lane_off, s);
      ee = bank_exp(prev_e, cur_e, even_en & dual_mode, even_lane_off, s);
      ec = (odd_en | even_en) & ((s < 2) || (s >= int'(NBITS) - 2));
      check_vec(wrapped ? "R2 odd repeat" : "R1 R3 R4 R5 R7 odd", odd_ser, eo);
      check_vec(wrapped ? "R2 even repeat" : "R1 R3 R4 R6 R7 even", even_ser, ee);
      check_vec("R8 clock lane", {{(LANES-1){1'b0}}, clk_ser}, {{(LANES-1){1'b0}}, ec});
   endtask

   task automatic run_frame(input bit wrap);
      logic [W-1:0] o_r, o_f, e_r, e_f;
      o_r = next_word(); o_f = next_word(); e_r = next_word(); e_f = next_word();
      @(negedge pix_clk); #1;
      odd_data = o_r; even_data = e_r;
      @(posedge pix_clk); #1;
      odd_data = o_f; even_data = e_f;
      @(negedge pix_clk);
      @(negedge fast_clk); load_stb = 1'b1;
      @(posedge fast_clk);
      @(negedge fast_clk); load_stb = 1'b0;
      prev_o = cur_o; cur_o = edge_sel ? o_r : o_f;   // R3
      prev_e = cur_e; cur_e = edge_sel ? e_r : e_f;
      for (int s = 0; s < (wrap ? 2*int'(NBITS) : int'(NBITS)); s++) begin
         if (s > 0) @(negedge fast_clk);
         check_slot(s % int'(NBITS), s >= int'(NBITS));
      end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      odd_data = next_word(); even_data = next_word();
      repeat (3) @(negedge fast_clk);
      check_vec("R9 odd in reset", odd_ser, '0);
      check_vec("R9 even in reset", even_ser, '0);
      rst_n = 1'b1;
      for (int k = 0; k < int'(NBITS); k++) begin
         @(negedge fast_clk);
         check_vec("R9 odd before load", odd_ser, '0);
         check_vec("R9 even before load", even_ser, '0);
      end
      for (int cfg = 0; cfg < 64; cfg++) begin
         int m;
         edge_sel  = cfg[0];
         odd_en    = cfg[1];
         even_en   = cfg[2];
         dual_mode = cfg[3];
         m = (cfg >> 4) & 3;
         odd_lane_off  = (m == 0) ? 5'h00 : (m == 1) ? 5'h15 : (m == 2) ? 5'h0A : 5'h1F;
         even_lane_off = (m == 0) ? 5'h00 : (m == 1) ? 5'h0A : (m == 2) ? 5'h13 : 5'h1F;
         run_frame(1'b0);
         run_frame(cfg[0] == 1'b1);
      end
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

endmodule